// File: doc/BRIEF.md
# Write-Once Security Lock Latch

This block is the digital wrapper around a 32-bit nonvolatile latch. When the latch holds a fixed key, the latch shuts off debug and test access for good. Software loads a key word into a volatile staging copy through a valid/ready write port. A separate program strobe then commits the staged word into the nonvolatile bits. The nonvolatile cells are modelled as a register that has no reset and keeps its value across reset. Its power-up content is a parameter.

A tolerant comparator counts how many stored bits agree with the fixed pattern 0x50536F43. The lock output is not driven by this comparison directly. It is a flag that is loaded from the comparison only while reset is asserted. So writing and programming the key changes nothing until the next reset. Once the flag is set, the stored bits are frozen and the write port stays closed. The stored bits remain visible on a plain read bus, so a locked part can still be identified.

The write port uses valid/ready. A word transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the part is locked or flash protection is active, and it can stay low indefinitely. The producer must not assume that a held word will ever be taken. The block has no buffering.

Top module: `wol_guard`

## Requirements
- R1: The match count is the number of positions where the stored bit equals the corresponding bit of 0x50536F43. After a reset, `lock` is 1 exactly when the count was at least 28 during reset.
- R2: A stored value with exactly 28 matching bits locks at the next reset. A value with 27 matching bits does not.
- R3: `lock` changes only on clock edges where `rst` is high. Writes and programming never change it while reset is low.
- R4: `wr_ready` equals NOT `lock` AND NOT `flash_prot`. A word is staged only on an edge with both `wr_valid` and `wr_ready` high.
- R5: A `prog` pulse on an edge with `lock` low and `rst` low copies the staged word into the stored bits. The copy shows on `rd_data` after that edge.
- R6: While `lock` is 1, `prog` leaves the stored bits unchanged.
- R7: The stored bits keep their value across reset. At power-up they hold the parameter NV_POWERUP.
- R8: `rd_data` always presents the stored bits, including while locked.
- R9: Reset clears the staged word to zero.
- R10: A write with `wr_valid` low, or with `flash_prot` high, leaves the staged word unchanged.
- R11: Once locked, the part stays locked through any number of further resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the lock flag is loaded from the comparison while this is high |
| wr_valid | input | 1 | Key word offered on `wr_data` |
| wr_ready | output | 1 | Staging copy may be written |
| wr_data | input | 32 | Key word to stage |
| prog | input | 1 | Commit the staged word into the nonvolatile bits |
| flash_prot | input | 1 | Flash protection is active; blocks key writes |
| lock | output | 1 | Debug and test access disabled |
| rd_data | output | 32 | Stored nonvolatile bits |

## Verification
The bench builds the block with NV_POWERUP set to the key with its low twelve bits inverted. This gives a 20-bit match at power-up, so the first reset must leave the part open while the read bus already shows a nonzero word. The key width and threshold stay at their defaults, 32 and 28. This brings the 27/28 boundary within reach by flipping chosen bits of the key. Random words and random words near that boundary go through stage, commit and reset. Only at the end is a 28-bit match committed, so the locked behaviour is exercised last.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned KEY_W     = 32;
  localparam logic [KEY_W-1:0] LOCK_KEY = 32'h5053_6F43;
  localparam int unsigned MIN_MATCH = 28;
endpackage

// File: rtl/wol_match.sv
module wol_match #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] PATTERN = '0,
  parameter int unsigned THRESH = 28,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0] word,
  output logic [CW-1:0] agree_cnt,
  output logic          hit
);
  logic [W-1:0] same;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign same[i] = ~(word[i] ^ PATTERN[i]);
    end
  endgenerate

  always_comb begin
    agree_cnt = '0;
    for (int i = 0; i < W; i++) agree_cnt = agree_cnt + CW'(same[i]);
  end

  assign hit = (agree_cnt >= CW'(THRESH));
endmodule

// File: rtl/wol_cells.sv
module wol_cells #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] NV_POWERUP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  input  logic         prog,
  input  logic         locked,
  input  logic         wr_valid,
  input  logic         wr_block,
  output logic [W-1:0] nv_bits
);
  logic [W-1:0] stage_q;
  logic [W-1:0] nv_q = NV_POWERUP;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else if (wr_fire) stage_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (prog && !locked && !rst) nv_q <= stage_q;
  end

  assign nv_bits = nv_q;

  assert_nv_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(nv_q));
  assert_prog_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (prog && !locked) |=> (nv_q == $past(stage_q)));
  assert_stage_held_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid || wr_block) |=> $stable(stage_q));
endmodule

// File: rtl/wol_guard.sv
module wol_guard
  import wol_pkg::*;
#(
  parameter int unsigned W = KEY_W,
  parameter logic [W-1:0] PATTERN = LOCK_KEY,
  parameter int unsigned THRESH = MIN_MATCH,
  parameter logic [W-1:0] NV_POWERUP = '0,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         prog,
  input  logic         flash_prot,
  output logic         lock,
  output logic [W-1:0] rd_data
);
  logic          lock_q;
  logic          hit;
  logic [CW-1:0] agree_cnt;
  logic [W-1:0]  nv_bits;
  logic          wr_block;

  assign wr_block = lock_q | flash_prot;
  assign wr_ready = ~wr_block;

  wol_cells #(.W(W), .NV_POWERUP(NV_POWERUP)) u_cells (
    .clk(clk), .rst(rst),
    .wr_fire(wr_valid & wr_ready), .wr_data(wr_data),
    .prog(prog), .locked(lock_q),
    .wr_valid(wr_valid), .wr_block(wr_block),
    .nv_bits(nv_bits)
  );

  wol_match #(.W(W), .PATTERN(PATTERN), .THRESH(THRESH)) u_match (
    .word(nv_bits), .agree_cnt(agree_cnt), .hit(hit)
  );

  // the lock decision is loaded only while reset is held
  always_ff @(posedge clk) begin
    if (rst) lock_q <= hit;
  end

  assign lock    = lock_q;
  assign rd_data = nv_bits;

  assert_lock_steady_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(lock_q));
  assert_locked_closed_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> !wr_ready);
endmodule

// File: tb/wol_guard_bench.sv
module wol_guard_bench;
  localparam logic [31:0] KEY = 32'h5053_6F43;
  localparam logic [31:0] PWR = KEY ^ 32'h0000_0FFF;

  logic clk = 0, rst = 0, wr_valid = 0, prog = 0, flash_prot = 0;
  logic [31:0] wr_data = '0;
  logic wr_ready, lock;
  logic [31:0] rd_data;
  int checks = 0, fails = 0;
  logic [31:0] stored, v;

  always #2.5 clk = ~clk;

  wol_guard #(.NV_POWERUP(PWR)) u_wol_guard (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .prog(prog), .flash_prot(flash_prot),
    .lock(lock), .rd_data(rd_data)
  );

  function automatic int agree(input logic [31:0] x);
    int n = 0;
    for (int i = 0; i < 32; i++) if (x[i] == KEY[i]) n++;
    return n;
  endfunction

  function automatic logic [31:0] flip_n(input int n, input int seed);
    logic [31:0] m = '0;
    int p = seed;
    while ($countones(m) < n) begin
      m[p % 32] = 1'b1;
      p = p + 7;
    end
    return KEY ^ m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic valid);
    @(negedge clk); wr_valid = valid; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic do_prog();
    @(negedge clk); prog = 1;
    @(negedge clk); prog = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    // R7: power-up value, 20 matches -> stays open
    chk("R7 powerup rd_data", rd_data, PWR);
    do_reset();
    chk("R1 reset lock", {31'b0, lock}, 32'd0);
    chk("R4 reset ready", {31'b0, wr_ready}, 32'd1);
    chk("R7 after reset", rd_data, PWR);
    stored = PWR;

    // R9: staged word cleared by reset
    do_prog();
    chk("R9 cleared stage committed", rd_data, 32'h0);
    stored = 0;

    // random stage/commit/reset rounds, all below threshold
    for (int k = 0; k < 24; k++) begin
      if (k % 2 == 0) v = $urandom();
      else v = flip_n(5 + ($urandom() % 6), int'($urandom() % 32));
      if (agree(v) >= 28) v = v ^ 32'h0000_00FF ^ (KEY & 32'h0000_00FF) ^ ~KEY & 32'h0;
      if (agree(v) >= 28) v = ~KEY;
      do_write(v, 1);
      do_prog();
      chk("R5 commit", rd_data, v);
      chk("R3 no lock before reset", {31'b0, lock}, 32'd0);
      do_reset();
      chk("R1 random lock decision", {31'b0, lock}, {31'b0, agree(v) >= 28});
      chk("R7 persist", rd_data, v);
      stored = v;
    end

    // R10: valid low is ignored
    do_write(KEY, 1);
    do_write(32'hDEAD_BEEF, 0);
    do_prog();
    chk("R10 valid low ignored", rd_data, KEY);
    // R10/R4: flash protection blocks staging
    flash_prot = 1;
    @(negedge clk);
    chk("R4 ready low under protection", {31'b0, wr_ready}, 32'd0);
    do_write(32'h1234_5678, 1);
    flash_prot = 0;
    do_prog();
    chk("R10 protected write ignored", rd_data, KEY);

    // R2: exactly 27 matches does not lock
    v = flip_n(5, 3);
    do_write(v, 1); do_prog();
    do_reset();
    chk("R2 27 matches no lock", {31'b0, lock}, 32'd0);

    // R2: exactly 28 matches locks, but only after reset (R3)
    v = flip_n(4, 11);
    do_write(v, 1); do_prog();
    chk("R3 still open before reset", {31'b0, lock}, 32'd0);
    do_reset();
    chk("R2 28 matches locks", {31'b0, lock}, 32'd1);
    chk("R8 readable locked", rd_data, v);
    chk("R4 ready low locked", {31'b0, wr_ready}, 32'd0);

    // R6: programming ignored while locked
    do_write(32'h0, 1);
    do_prog();
    chk("R6 prog ignored", rd_data, v);
    do_reset();
    chk("R11 stays locked", {31'b0, lock}, 32'd1);
    do_prog();
    chk("R6 prog ignored after reset", rd_data, v);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule